// File: doc/BRIEF.md
# Command-Queued SPI Frame Sequencer

This block is the queueing front end of an SPI master. Software writes 32-bit entries into a four-deep transmit queue. The upper half of each entry is a per-frame command word. The lower half is the 16-bit word to shift out. The sequencer takes entries one at a time and hands the data to a frame engine. While the frame runs, it drives the chip-select lines the command names. After the frame it either releases those lines or holds them for the next frame.

Every completed frame has three results. The received word goes into a four-deep receive queue, which is drained through a pop port. A 16-bit frame counter advances. Sticky status flags are set and can raise an interrupt. A command can do two more things. It can mark its frame as the end of the queue, which stops the sequencer until software acknowledges the flag. It can also restart the frame counter. The frame engine in this project is a simple behavioural stand-in: 16 bits, MSB first, two clocks per bit.

The register interface is a write port with a 2-bit select:

- 0 is control.
- 1 is status, write-one-to-clear.
- 2 is interrupt enable.
- 3 is the transmit push.

Status and the count register are visible as output ports.

Top module: `spi_cmd_queue`

## Requirements
- R1: After reset:
  - all chip selects sit at their inactive level, which is all ones;
  - the status word is 0x0200_0000, with only transmit-not-full set;
  - the count register reads zero;
  - irq is low;
  - the receive queue is empty.
- R2: Each frame shifts the entry's bits 15:0 out on mosi, MSB first, one bit per sck high phase. With mosi looped to miso, the word popped from the receive queue equals the word sent.
- R3: Command bits 5:0 name the chip selects used by the frame; each named line is driven to the inverse of its inactive level for the frame. Command bit 15 is continuous-select. When it is clear, the lines return to their inactive level the cycle after the frame ends. When it is set, they stay asserted after the frame.
- R4: The frame counter sits in count register bits 31:16 and increases by one for each completed frame.
- R5: When command bit 10 is set, the counter is restarted before its frame is counted, so the counter reads 1 after that frame.
- R6: Command bit 11 marks end of queue. When its frame completes, status bit 28 is set and no further entry starts until a write with bit 28 set reaches the status register. Such a write clears the flag and resumes the queue.
- R7: Status bit 31 is set by each completed frame. Writing one to it clears it. Writing zero leaves it unchanged.
- R8: Status bit 25 reads 1 while the transmit queue has room, and status bit 17 reads 1 while the receive queue holds a word.
- R9: Once the receive queue holds four words, a further frame's word is discarded and sticky status bit 19 is set; the four stored words keep their order. Bit 19 clears on a write-one.
- R10: A push into a full transmit queue is ignored.
- R11: In the control register:
  - writing bit 11 empties the transmit queue;
  - writing bit 10 empties the receive queue;
  - bits 21:16 set the inactive level of each chip select.
- R12: irq is high exactly when (status bit 31 and enable bit 31) or (status bit 28 and enable bit 28).
- R13: cfg_sel carries command bits 14:12 of the running frame and holds steady throughout it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 interrupt enable, 3 transmit push |
| reg_wdata | input | 32 | Write data |
| rx_pop | input | 1 | Remove the head word of the receive queue |
| rx_data | output | 16 | Head word of the receive queue |
| rx_avail | output | 1 | Receive queue not empty |
| status_o | output | 32 | Status word |
| count_o | output | 32 | Count register, frame counter in bits 31:16 |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Chip-select lines |
| cfg_sel | output | 3 | Timing configuration of the running frame |

## Verification
The bench loops mosi back to miso, so every received word can be predicted from the word sent. It first sweeps single-frame commands across all six chip selects with a different data word and timing code each time. This separates a wrong chip-select decode, bit order or configuration pass-through. Because this sweep overruns the receive queue, it also exposes a wrong drop-versus-keep policy. Queued multi-frame commands, issued while the sequencer is halted, separate the end-of-queue stop from ordinary draining. The same test catches counter restart against increment, and a push into a full queue against a stored push. Flushes, inactive-level changes and interrupt-enable combinations then isolate each control and status field.

// File: rtl/spi_cq_pkg.sv
// Package: shared field layout for the command-queued SPI sequencer.
// Assumes a 16-bit command half with the bit positions below.
package spi_cq_pkg;

    localparam int NCS = 6;

    typedef struct packed {
        logic           keep_cs;   // 15: hold chip select after frame
        logic [2:0]     cfg;       // 14:12 timing configuration
        logic           end_q;     // 11: stop queue after frame
        logic           cnt_clr;   // 10: restart frame counter
        logic [3:0]     spare;     // 9:6 unused
        logic [NCS-1:0] cs_en;     // 5:0 chip-select enables
    } cmd_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_PUSH = 2'd3
    } reg_sel_e;

    localparam int ST_TCF  = 31;
    localparam int ST_EOQ  = 28;
    localparam int ST_TXNF = 25;
    localparam int ST_RXOV = 19;
    localparam int ST_RXNE = 17;

    localparam int CT_FLUSH_TX = 11;
    localparam int CT_FLUSH_RX = 10;
    localparam int CT_IDLE_LO  = 16;

endpackage

// File: rtl/spi_cq_fifo.sv
// Module: synchronous FIFO with a flush input.
// Assumes DEPTH is a power of two; the head word is shown combinationally.
// A push when full and a pop when empty are both ignored.
module spi_cq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    // Pointer update; flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wp[AW-1:0]] <= wdata;
    end

endmodule

// File: rtl/spi_cq_engine.sv
// Module: behavioural frame engine stand-in.
// Shifts BITS bits MSB first. Each bit takes two clocks: sck high, then sck low.
// miso is sampled as sck rises. done pulses one cycle after the last bit.
module spi_cq_engine #(
    parameter int BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_word,
    output logic            busy,
    output logic            done,
    output logic [BITS-1:0] rx_word,
    output logic            sck,
    output logic            mosi,
    input  logic            miso
);
    localparam int CW = $clog2(BITS);

    logic [BITS-1:0] tx_sh;
    logic [CW-1:0]   bit_idx;

    assign mosi = tx_sh[BITS-1];

    // Bit sequencing: load, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sck     <= 1'b0;
            tx_sh   <= '0;
            rx_word <= '0;
            bit_idx <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                tx_sh   <= tx_word;
                bit_idx <= '0;
                sck     <= 1'b0;
            end else if (busy && !sck) begin
                sck     <= 1'b1;
                rx_word <= {rx_word[BITS-2:0], miso};
            end else if (busy) begin
                sck   <= 1'b0;
                tx_sh <= tx_sh << 1;
                if (bit_idx == CW'(BITS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_cq_status.sv
// Module: sticky status flags, interrupt enables and the interrupt output.
// Assumes a set and a clear of the same flag in one cycle resolve to set.
module spi_cq_status (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_tcf,
    input  logic        set_eoq,
    input  logic        set_ovf,
    input  logic        clr_we,
    input  logic        ien_we,
    input  logic [31:0] wdata,
    input  logic        tx_not_full,
    input  logic        rx_not_empty,
    output logic [31:0] status,
    output logic        eoq_flag,
    output logic        irq
);
    import spi_cq_pkg::*;

    logic tcf_flag;
    logic ovf_flag;
    logic ien_tcf;
    logic ien_eoq;

    // Sticky flags, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcf_flag <= 1'b0;
            eoq_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            tcf_flag <= set_tcf | (tcf_flag & ~(clr_we & wdata[ST_TCF]));
            eoq_flag <= set_eoq | (eoq_flag & ~(clr_we & wdata[ST_EOQ]));
            ovf_flag <= set_ovf | (ovf_flag & ~(clr_we & wdata[ST_RXOV]));
        end
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_tcf <= 1'b0;
            ien_eoq <= 1'b0;
        end else if (ien_we) begin
            ien_tcf <= wdata[ST_TCF];
            ien_eoq <= wdata[ST_EOQ];
        end
    end

    // Status word assembly.
    always_comb begin
        status          = '0;
        status[ST_TCF]  = tcf_flag;
        status[ST_EOQ]  = eoq_flag;
        status[ST_TXNF] = tx_not_full;
        status[ST_RXOV] = ovf_flag;
        status[ST_RXNE] = rx_not_empty;
    end

    assign irq = (tcf_flag & ien_tcf) | (eoq_flag & ien_eoq);

endmodule

// File: rtl/spi_cmd_queue.sv
// Module: top of the command-queued SPI frame sequencer.
// Pops command+data entries, runs one frame each, steers the chip selects,
// counts frames and stores received words. It halts while the end-of-queue
// flag is set. Assumes one frame in flight at a time.
module spi_cmd_queue #(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int CNT_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        rx_pop,
    output logic [15:0] rx_data,
    output logic        rx_avail,
    output logic [31:0] status_o,
    output logic [31:0] count_o,
    output logic        irq,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [5:0]  cs_n,
    output logic [2:0]  cfg_sel
);
    import spi_cq_pkg::*;

    localparam int DW = 16;

    logic        we_ctrl, we_stat, we_ien, we_push;
    logic        flush_tx, flush_rx;
    logic [31:0] tx_head;
    logic        tx_empty, tx_full;
    logic        rx_empty, rx_full;
    logic        start, inflight, eoq_flag;
    logic        eng_busy, eng_done;
    logic [DW-1:0] eng_rx;
    cmd_t        head_cmd, cur_cmd;
    logic [NCS-1:0] cs_act, cs_idle;
    logic [CNT_W-1:0] frame_cnt;

    assign we_ctrl  = reg_we && (reg_sel == SEL_CTRL);
    assign we_stat  = reg_we && (reg_sel == SEL_STAT);
    assign we_ien   = reg_we && (reg_sel == SEL_IEN);
    assign we_push  = reg_we && (reg_sel == SEL_PUSH);
    assign flush_tx = we_ctrl && reg_wdata[CT_FLUSH_TX];
    assign flush_rx = we_ctrl && reg_wdata[CT_FLUSH_RX];

    assign head_cmd = cmd_t'(tx_head[31:16]);
    assign start    = !inflight && !tx_empty && !eoq_flag;

    spi_cq_fifo #(.W(32), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx),
        .push(we_push), .wdata(reg_wdata),
        .pop(start), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spi_cq_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx),
        .push(eng_done), .wdata(eng_rx),
        .pop(rx_pop), .rdata(rx_data),
        .empty(rx_empty), .full(rx_full)
    );

    spi_cq_engine #(.BITS(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tx_word(tx_head[DW-1:0]),
        .busy(eng_busy), .done(eng_done), .rx_word(eng_rx),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    spi_cq_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_tcf(eng_done),
        .set_eoq(eng_done && cur_cmd.end_q),
        .set_ovf(eng_done && rx_full),
        .clr_we(we_stat), .ien_we(we_ien), .wdata(reg_wdata),
        .tx_not_full(!tx_full), .rx_not_empty(!rx_empty),
        .status(status_o), .eoq_flag(eoq_flag), .irq(irq)
    );

    // Frame bookkeeping: latch command at start, settle selects and counter at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight  <= 1'b0;
            cur_cmd   <= '0;
            cs_act    <= '0;
            frame_cnt <= '0;
        end else if (start) begin
            inflight <= 1'b1;
            cur_cmd  <= head_cmd;
            cs_act   <= head_cmd.cs_en;
        end else if (eng_done) begin
            inflight  <= 1'b0;
            if (!cur_cmd.keep_cs) cs_act <= '0;
            frame_cnt <= cur_cmd.cnt_clr ? CNT_W'(1) : frame_cnt + 1'b1;
        end
    end

    // Inactive chip-select levels from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cs_idle <= '1;
        else if (we_ctrl) cs_idle <= reg_wdata[CT_IDLE_LO +: NCS];
    end

    assign cs_n     = cs_idle ^ cs_act;
    assign cfg_sel  = cur_cmd.cfg;
    assign rx_avail = !rx_empty;
    assign count_o  = {frame_cnt, {(32 - CNT_W){1'b0}}};

endmodule

// File: rtl/spi_cmd_queue_chk.sv
// Module: assertion checker bound to spi_cmd_queue.
// Observes engine handshakes, the latched command and the outputs.
module spi_cmd_queue_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              eng_done,
    input logic              eng_busy,
    input logic              rx_full,
    input spi_cq_pkg::cmd_t  cur_cmd,
    input logic [5:0]        cs_idle,
    input logic [5:0]        cs_n,
    input logic [31:0]       status_o,
    input logic [31:0]       count_o,
    input logic [2:0]        cfg_sel
);
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !cur_cmd.keep_cs |=> cs_n == cs_idle); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !cur_cmd.cnt_clr |=> count_o[31:16] == $past(count_o[31:16]) + 16'd1); // R4
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && cur_cmd.cnt_clr |=> count_o[31:16] == 16'd1); // R5
    AST_EOQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && cur_cmd.end_q |=> status_o[28]); // R6
    AST_NO_START_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> !status_o[28]); // R6
    AST_TCF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> status_o[31]); // R7
    AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && rx_full |=> status_o[19]); // R9
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy && $past(eng_busy) |-> $stable(cfg_sel)); // R13
endmodule

bind spi_cmd_queue spi_cmd_queue_chk u_chk (
    .clk(clk), .rst_n(rst_n), .eng_done(eng_done), .eng_busy(eng_busy),
    .rx_full(rx_full), .cur_cmd(cur_cmd), .cs_idle(cs_idle), .cs_n(cs_n),
    .status_o(status_o), .count_o(count_o), .cfg_sel(cfg_sel)
);

// File: tb/spi_cmd_queue_bench.sv
module spi_cmd_queue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_data;
    logic        rx_avail;
    logic [31:0] status_o, count_o;
    logic        irq, sck, mosi;
    logic [5:0]  cs_n;
    logic [2:0]  cfg_sel;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    spi_cmd_queue u_spi_cmd_queue (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_avail(rx_avail), .status_o(status_o), .count_o(count_o),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(mosi), .cs_n(cs_n),
        .cfg_sel(cfg_sel)
    );

    // Serial monitor: collects bits on sck rising, with cs and cfg seen then.
    logic        prev_sck = 1'b0;
    logic [15:0] mon_sh = '0, mon_word = '0;
    logic [5:0]  mon_cs = '0;
    logic [2:0]  mon_cfg = '0;
    int          mon_bits = 0;
    int          mon_frames = 0;
    always @(negedge clk) begin
        if (sck && !prev_sck) begin
            if (mon_bits == 15) begin
                mon_word   <= {mon_sh[14:0], mosi};
                mon_cs     <= cs_n;
                mon_cfg    <= cfg_sel;
                mon_frames <= mon_frames + 1;
                mon_bits   <= 0;
            end else begin
                mon_bits <= mon_bits + 1;
            end
            mon_sh <= {mon_sh[14:0], mosi};
        end
        prev_sck <= sck;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic push(input logic [15:0] cmd, input logic [15:0] d);
        wr(2'd3, {cmd, d});
    endtask

    task automatic wait_eoq();
        for (int i = 0; i < 3000; i++) begin
            if (status_o[28]) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_expect(input string req, input logic [15:0] exp);
        chk(req, {31'd0, rx_avail}, 32'd1);
        chk(req, {16'd0, rx_data}, {16'd0, exp});
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    function automatic logic [15:0] pat(input int k);
        return 16'hA5C3 ^ 16'(k * 16'h1357);
    endfunction

    localparam logic [15:0] C_KEEP = 16'h8000;
    localparam logic [15:0] C_EOQ  = 16'h0800;
    localparam logic [15:0] C_CLR  = 16'h0400;

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", {26'd0, cs_n}, 32'h3F);
        chk("R1 status", status_o, 32'h0200_0000);
        chk("R1 count", count_o, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rx_avail", {31'd0, rx_avail}, 32'd0);

        // Sweep every chip select with its own data and cfg code
        for (int k = 0; k < 6; k++) begin
            push(16'(1 << k) | 16'((k % 8) << 12) | C_EOQ | (k == 0 ? C_CLR : 16'h0), pat(k));
            wait_eoq();
            chk("R2 mosi word", {16'd0, mon_word}, {16'd0, pat(k)});
            chk("R3 cs during frame", {26'd0, mon_cs}, {26'd0, 6'h3F ^ 6'(1 << k)});
            chk("R3 cs released", {26'd0, cs_n}, 32'h3F);
            chk("R13 cfg", {29'd0, mon_cfg}, 32'(k % 8));
            chk("R4 count", count_o, 32'(k + 1) << 16);
            chk("R7 tcf set", {31'd0, status_o[31]}, 32'd1);
            chk("R6 eoq set", {31'd0, status_o[28]}, 32'd1);
            if (k == 4) chk("R9 overflow set", {31'd0, status_o[19]}, 32'd1);
            wr(2'd1, 32'h9000_0000);
            chk("R7 tcf cleared", {31'd0, status_o[31]}, 32'd0);
        end
        chk("R8 rx not empty", {31'd0, status_o[17]}, 32'd1);
        for (int k = 0; k < 4; k++) pop_expect("R9 kept order", pat(k));
        chk("R8 rx empty", {31'd0, status_o[17]}, 32'd0);
        wr(2'd1, 32'h0008_0000);
        chk("R9 overflow cleared", {31'd0, status_o[19]}, 32'd0);

        // End-of-queue stop and resume
        push(16'h0002 | C_CLR | C_EOQ, 16'h1234);
        push(16'h0002 | C_KEEP, 16'h5678);
        push(16'h0002 | C_EOQ, 16'h9ABC);
        wait_eoq();
        idle(100);
        chk("R5 counter restarted", count_o, 32'h0001_0000);
        chk("R6 halted", count_o, 32'h0001_0000);
        wr(2'd1, 32'h1000_0000);
        wait_eoq();
        chk("R6 resumed", count_o, 32'h0003_0000);
        chk("R2 last word", {16'd0, mon_word}, 32'h9ABC);
        chk("R3 cs idle after", {26'd0, cs_n}, 32'h3F);
        pop_expect("R2 loopback", 16'h1234);
        pop_expect("R2 loopback", 16'h5678);
        pop_expect("R2 loopback", 16'h9ABC);

        // Continuous select holds after the frame
        wr(2'd1, 32'h1000_0000);
        push(16'h0008 | C_KEEP | C_EOQ, 16'h00AA);
        wait_eoq();
        chk("R3 cs held", {26'd0, cs_n}, 32'h37);
        wr(2'd1, 32'h1000_0000);
        idle(20);
        chk("R3 cs still held", {26'd0, cs_n}, 32'h37);
        push(16'h0008 | C_EOQ, 16'h00BB);
        wait_eoq();
        chk("R3 cs released", {26'd0, cs_n}, 32'h3F);
        rx_pop = 1'b1; idle(2); rx_pop = 1'b0;

        // Push into a full queue while halted
        for (int i = 0; i < 5; i++) begin
            push(16'h0004 | (i == 3 ? C_EOQ : 16'h0) | (i == 0 ? C_CLR : 16'h0), 16'hC000 | 16'(i));
            if (i == 3) chk("R8 tx full", {31'd0, status_o[25]}, 32'd0);
        end
        wr(2'd1, 32'h1000_0000);
        wait_eoq();
        chk("R10 four frames", count_o, 32'h0004_0000);
        chk("R8 tx not full", {31'd0, status_o[25]}, 32'd1);
        wr(2'd1, 32'h1000_0000);
        idle(200);
        chk("R10 fifth push dropped", count_o, 32'h0004_0000);
        for (int i = 0; i < 4; i++) pop_expect("R10 stored entries", 16'hC000 | 16'(i));
        chk("R8 rx drained", {31'd0, rx_avail}, 32'd0);

        // Flushes
        push(16'h0001 | C_EOQ, 16'h0F0F);
        wait_eoq();
        push(16'h0001, 16'h1111);
        push(16'h0001, 16'h2222);
        wr(2'd0, 32'h003F_0800);
        wr(2'd1, 32'h1000_0000);
        idle(200);
        chk("R11 tx flushed", count_o, 32'h0005_0000);
        chk("R11 rx before flush", {31'd0, rx_avail}, 32'd1);
        wr(2'd0, 32'h003F_0400);
        chk("R11 rx flushed", {31'd0, rx_avail}, 32'd0);
        wr(2'd0, 32'h0015_0000);
        chk("R11 inactive level", {26'd0, cs_n}, 32'h15);
        base = mon_frames;
        push(16'h0001 | C_EOQ | C_CLR, 16'h00FF);
        wait_eoq();
        chk("R11 cs inverted level", {26'd0, mon_cs}, 32'h14);
        chk("R5 restart", count_o, 32'h0001_0000);
        chk("R2 one frame", 32'(mon_frames - base), 32'd1);
        wr(2'd0, 32'h003F_0000);

        // Interrupt combinations
        chk("R12 none enabled", {31'd0, irq}, 32'd0);
        wr(2'd2, 32'h8000_0000);
        chk("R12 tcf enabled", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h0000_0000);
        chk("R7 write zero keeps", {31'd0, status_o[31]}, 32'd1);
        wr(2'd1, 32'h8000_0000);
        chk("R12 tcf cleared", {31'd0, irq}, 32'd0);
        wr(2'd2, 32'h9000_0000);
        chk("R12 eoq enabled", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'h0000_0000);
        chk("R12 disabled", {31'd0, irq}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule